// File: doc/BRIEF.md
# Phase Interpolator Select Controller

This block drives the digital selects of a fractional-N feedback path in which a quadrature divider supplies four clock phases, spaced a quarter period apart, to a three-stage pipelined phase interpolator. Each update, a phase step from a waveform generator or a noise-shaping modulator is added to a fractional position register that wraps modulo 32. The position is split into a quadrant and three fine bits. The quadrant picks which adjacent pair of divider phases the rotation logic passes on. Each fine bit tells one interpolation stage which of its three candidates (quarter, half or three-quarter point between its two inputs) to forward.

The stage selects are registered so that they line up with the pipeline: stage 1 changes together with the quadrant select, and each later stage follows one edge after the stage before it. The register changes only on a clock edge at which an update or load strobe is sampled, so no stage sees a half-applied word. When an accumulating update carries out of the top quadrant back to quadrant 0, the block raises a one-cycle carry pulse, aligned with the quadrant change, that the divider counts as one extra input cycle. This keeps the synthesized phase continuous across the wrap.

Top module: `pi_sel_ctrl`

## Requirements
- R1: While rst_n is low, quad_o is 4'b0001, every stage select is the centre code 3'b010, wrap_o is 0 and the position register is 0.
- R2: At a rising edge with upd_i=1 and load_i=0, the 5-bit position becomes (position + step_i) mod 32.
- R3: At a rising edge with load_i=1, the position becomes code_i regardless of upd_i and step_i, and no carry pulse is produced for that edge.
- R4: At an edge with upd_i=0 and load_i=0, the position holds, whatever step_i and code_i carry, so quad_o stays unchanged two edges later.
- R5: quad_o is one-hot with bit q set for quadrant q = position[4:3]. Bit q names the phase pair (q·90°, (q+1)·90° mod 360°). It shows the position written at edge n after edge n+1.
- R6: Stage k (k=1..3, bits [3k-1:3k-3] of stage_sel_o) is driven by position bit 3-k. A 0 gives the lower candidate 3'b001 (quarter point) and a 1 gives the upper candidate 3'b100 (three-quarter point). Stage 1 changes together with quad_o.
- R7: Stage k's select lags stage 1 by k-1 edges. Before a stage's pipeline has filled after reset, it shows the centre code 3'b010, and never once it has filled.
- R8: wrap_o is a one-cycle pulse, raised together with quad_o, for each accumulating update whose sum reaches 32 or more. A wrap never moves the quadrant index upward.
- R9: With a step of 8 or less, successive quadrants are equal or advance by one, and the move from quadrant 3 to quadrant 0 comes with a wrap_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Accumulate step_i at this edge |
| load_i | input | 1 | Load code_i into the position at this edge (has priority) |
| code_i | input | 5 | Absolute phase position for a load |
| step_i | input | 5 | Phase increment per update |
| quad_o | output | 4 | One-hot quadrant pair select for the rotation logic |
| stage_sel_o | output | 9 | Three one-hot stage selects, stage 1 in the low bits |
| wrap_o | output | 1 | Extra-count pulse to the divider on a quadrant wrap |

## Verification
If the position register held a wrong value, quad_o and the stage 1 select would show it one edge after the faulty update. Stages 2 and 3 would repeat the error one and two edges later, so a single bad position shows up three times. A misaligned stage pipeline shows up as a stage select that disagrees with the expected delayed bit, or as a centre code lingering past the fill window. A lost or extra carry shows up as a missing or spurious wrap_o in the same cycle that quad_o returns to quadrant 0. A ramp that steps through every position exposes all of these within one lap of 32 updates.

// File: rtl/pi_sel_ctrl.sv
module pi_sel_ctrl #(
  parameter int FINE_W = 3,
  localparam int POS_W = FINE_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_i,
  input  logic                  load_i,
  input  logic [POS_W-1:0]      code_i,
  input  logic [POS_W-1:0]      step_i,
  output logic [3:0]            quad_o,
  output logic [3*FINE_W-1:0]   stage_sel_o,
  output logic                  wrap_o
);

  localparam logic [2:0] SEL_LO  = 3'b001;
  localparam logic [2:0] SEL_MID = 3'b010;
  localparam logic [2:0] SEL_HI  = 3'b100;

  logic [POS_W-1:0] pos_q;
  logic [POS_W:0]   sum;
  logic             carry_q;

  assign sum = {1'b0, pos_q} + {1'b0, step_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      carry_q <= 1'b0;
      wrap_o  <= 1'b0;
      quad_o  <= 4'b0001;
    end else begin
      if (load_i)     pos_q <= code_i;
      else if (upd_i) pos_q <= sum[POS_W-1:0];
      carry_q <= upd_i & ~load_i & sum[POS_W];
      wrap_o  <= carry_q;
      quad_o  <= 4'b0001 << pos_q[POS_W-1 -: 2];
    end
  end

  for (genvar k = 0; k < FINE_W; k++) begin : g_stage
    logic [2:0] pipe_q [k+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int j = 0; j <= k; j++) pipe_q[j] <= SEL_MID;
      end else begin
        pipe_q[0] <= pos_q[FINE_W-1-k] ? SEL_HI : SEL_LO;
        for (int j = 1; j <= k; j++) pipe_q[j] <= pipe_q[j-1];
      end
    end
    assign stage_sel_o[3*k +: 3] = pipe_q[k];
  end

endmodule

// File: rtl/pi_sel_ctrl_chk.sv
module pi_sel_ctrl_chk #(
  parameter int FINE_W = 3,
  localparam int POS_W = FINE_W + 2,
  localparam int CW = $clog2(FINE_W + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_i,
  input logic                load_i,
  input logic [3:0]          quad_o,
  input logic [3*FINE_W-1:0] stage_sel_o,
  input logic                wrap_o
);

  logic [CW-1:0] fill_cnt;
  logic [1:0]    qidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else if (fill_cnt != CW'(FINE_W)) fill_cnt <= fill_cnt + 1'b1;
  end

  always_comb begin
    qidx = 2'd0;
    for (int i = 0; i < 4; i++) if (quad_o[i]) qidx = 2'(i);
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (quad_o == 4'b0001 && !wrap_o)); // R1
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !$past(upd_i || load_i, 2) |-> $stable(quad_o)); // R4
  AST_QUAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(quad_o)); // R5
  AST_WRAP_FROM_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) wrap_o |-> $past(upd_i && !load_i, 2)); // R8
  AST_WRAP_NOT_UPWARD: assert property (@(posedge clk) disable iff (!rst_n) wrap_o |-> (qidx <= $past(qidx))); // R8

  for (genvar k = 0; k < FINE_W; k++) begin : g_chk
    AST_STAGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(stage_sel_o[3*k +: 3])); // R6
    AST_FILLED_NO_CENTRE: assert property (@(posedge clk) disable iff (!rst_n) (fill_cnt == CW'(FINE_W)) |-> !stage_sel_o[3*k+1]); // R7
  end

endmodule

bind pi_sel_ctrl pi_sel_ctrl_chk #(.FINE_W(FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .load_i(load_i),
  .quad_o(quad_o), .stage_sel_o(stage_sel_o), .wrap_o(wrap_o)
);

// File: tb/tb_pi_sel_ctrl.sv
module tb_pi_sel_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_i = 1'b0, load_i = 1'b0;
  logic [4:0] code_i = '0, step_i = '0;
  logic [3:0] quad_o;
  logic [8:0] stage_sel_o;
  logic wrap_o;

  pi_sel_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int checks = 0, failures = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [4:0] model = '0;

  int         q_due[$];
  logic [4:0] q_pos[$];
  logic       q_wrap[$];
  string      q_tag[$];
  logic [2:0] h2, h3a, h3b;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] dec(input logic b);
    return b ? 3'b100 : 3'b001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic drive(input logic u, input logic l, input logic [4:0] c, input logic [4:0] s, input string tag);
    logic [5:0] t;
    logic w;
    upd_i = u; load_i = l; code_i = c; step_i = s;
    w = 1'b0;
    if (l) model = c;
    else if (u) begin
      t = {1'b0, model} + {1'b0, s};
      model = t[4:0];
      w = t[5];
    end
    q_due.push_back(cyc + 2); q_pos.push_back(model); q_wrap.push_back(w); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on && q_due.size() > 0 && q_due[0] == cyc) begin
      logic [4:0] p;
      string tg;
      p = q_pos.pop_front(); tg = q_tag.pop_front();
      void'(q_due.pop_front());
      chk({"R5 quad ", tg}, 32'(quad_o), 32'(4'b0001 << p[4:3]));
      chk({"R6 stage1 ", tg}, 32'(stage_sel_o[2:0]), 32'(dec(p[2])));
      chk({"R7 stage2 ", tg}, 32'(stage_sel_o[5:3]), 32'(h2));
      chk({"R7 stage3 ", tg}, 32'(stage_sel_o[8:6]), 32'(h3b));
      chk({"R8 wrap ", tg}, 32'(wrap_o), 32'(q_wrap.pop_front()));
      h3b = h3a; h3a = dec(p[0]); h2 = dec(p[1]);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 quad", 32'(quad_o), 32'h1);
    chk("R1 stages", 32'(stage_sel_o), 32'b010_010_010);
    chk("R1 wrap", 32'(wrap_o), 32'h0);
    h2 = 3'b001; h3a = 3'b001; h3b = 3'b010;
    rst_n = 1'b1; mon_on = 1'b1;
    drive(0, 0, 5'd0, 5'd0, "R4 idle");
    drive(0, 0, 5'd0, 5'd0, "R4 idle");
    for (int i = 0; i < 40; i++) drive(1, 0, 5'd0, 5'd1, "R9 unit ramp");
    for (int i = 0; i < 10; i++) drive(1, 0, 5'd0, 5'd5, "R2 step5");
    for (int i = 0; i < 4; i++) drive(0, 0, 5'd17, 5'd7, "R4 hold");
    drive(0, 1, 5'd29, 5'd0, "R3 load");
    drive(1, 1, 5'd6, 5'd10, "R3 load priority");
    drive(0, 0, 5'd0, 5'd0, "R3 after");
    for (int i = 0; i < 6; i++) drive(1, 0, 5'd0, 5'd31, "R8 big step");
    for (int i = 0; i < 10; i++) drive(1, 0, 5'd0, 5'd8, "R9 step8");
    for (int i = 0; i < 3; i++) drive(1, 0, 5'd0, 5'd0, "R4 zero step");
    for (int i = 0; i < 4; i++) drive(0, 0, 5'd0, 5'd0, "R2 drain");
    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 32'(q_due.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule